// File: doc/BRIEF.md
# Multicycle Load/Store Processor Core

This block is a compact processor core that runs a five-instruction subset of a classic 32-bit load/store instruction set: load word, store word, add immediate, register add and branch-if-equal. Each instruction takes several clock cycles. A finite state machine steps through fetch, decode, execute or address, memory and write-back phases, and each instruction uses only the phases it needs.

The core has one memory port, which serves both instruction fetch and data access. The port has a combinational read path, and a write is committed at the clock edge while the write strobe is high. There is no separate program-counter adder. The single ALU adds 4 to the PC during fetch, and it also computes branch targets, effective addresses and results.

A branch target is computed during decode and held in a dedicated register. The equality test runs one cycle later. The core sits next to a unified memory and needs no other connection apart from clock and reset.

Top module: `mcCore`

## Requirements
- R1: While synchronous active-low reset is held, and in the first cycle after it is released, the core drives memAddr = 0 and memWe = 0. The first instruction is fetched from byte address 0.
- R2: In every fetch cycle the memory address is the PC. The fetched word is latched as the instruction, and the PC becomes PC+4 through the main ALU. Every instruction does this, branches included. Data accesses present the ALU output register as the address.
- R3: Instruction fields are: opcode = bits 31:26, rs = 25:21, rt = 20:16, rd = 15:11, funct = 5:0 and immediate = 15:0. The opcodes are: load = 0x23, store = 0x2B, add-immediate = 0x08, branch-equal = 0x04, and register format = 0x00 with funct 0x20 for add.
- R4: Add-immediate writes rs + sign-extended immediate into rt. It takes 4 cycles.
- R5: Register add writes rs + rt into rd. It takes 4 cycles.
- R6: Load reads the word at rs + sign-extended immediate into rt. It takes 5 cycles.
- R7: Store writes rt to the address rs + sign-extended immediate. It takes 4 cycles, and memWe is high only in the 4th cycle, for exactly one cycle.
- R8: Branch-equal computes the target (PC+4) + (sign-extended offset × 4) in the decode cycle and holds it in the target register. It compares rs with rt in the next cycle. If they are equal, the PC is loaded from the target register; otherwise the PC keeps PC+4. The branch takes 3 cycles.
- R9: Register 0 always reads as zero, and writes to it have no effect.
- R10: An opcode or funct outside R3 returns to fetch after the decode cycle, 2 cycles in all. It writes neither a register nor memory, and execution continues at the next word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| memAddr | output | 32 | Byte address for the shared memory port |
| memWdata | output | 32 | Store data |
| memWe | output | 1 | Write strobe, one cycle per store |
| memRdata | input | 32 | Read data for memAddr, valid in the same cycle |

## Verification
The core's internal state can only be seen through the stores it performs. Each store carries a register value, an address and a cycle number, and all three are checked. A wrong PC, a wrong target register or a register-file error therefore shows up at the next store that depends on it. A wrong cycle count, such as an extra or missing phase, moves every later store by the same number of cycles, so it appears as a timing mismatch at the first store after the faulty instruction.

// File: rtl/mcPkg.sv
package mcPkg;
  localparam int XLEN = 32;
  localparam int REG_COUNT = 32;
  localparam int REG_IDX_W = $clog2(REG_COUNT);
  localparam int IMM_W = 16;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] FN_ADD   = 6'h20;

  typedef enum logic [1:0] {
    SRCB_REG,
    SRCB_FOUR,
    SRCB_IMM,
    SRCB_IMMSH
  } srcBSel_e;

  typedef enum logic [3:0] {
    ST_FETCH,
    ST_DECODE,
    ST_ADDR,
    ST_MEMRD,
    ST_WBMEM,
    ST_MEMWR,
    ST_EXEI,
    ST_WBI,
    ST_EXER,
    ST_WBR,
    ST_BRANCH
  } coreState_e;

  typedef struct packed {
    logic     pcWrite;
    logic     pcWriteCond;
    logic     pcSrcTarget;
    logic     iOrD;
    logic     memWrite;
    logic     irWrite;
    logic     mdrWrite;
    logic     regWrite;
    logic     regDstRd;
    logic     memToReg;
    logic     srcAReg;
    srcBSel_e srcB;
    logic     aluSub;
    logic     targetWrite;
    logic     aluOutWrite;
  } strobes_t;
endpackage

// File: rtl/mcAlu.sv
module mcAlu
  import mcPkg::*;
#(
  parameter int WIDTH = XLEN
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             sub,
  output logic [WIDTH-1:0] result,
  output logic             zero
);
  always_comb begin
    if (sub) result = opA - opB;
    else     result = opA + opB;
    zero = (result == '0);
  end
endmodule

// File: rtl/mcRegFile.sv
module mcRegFile
  import mcPkg::*;
#(
  parameter int WIDTH = XLEN,
  parameter int COUNT = REG_COUNT
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [$clog2(COUNT)-1:0] rdAddrA,
  input  logic [$clog2(COUNT)-1:0] rdAddrB,
  output logic [WIDTH-1:0]         rdDataA,
  output logic [WIDTH-1:0]         rdDataB,
  input  logic                     wrEn,
  input  logic [$clog2(COUNT)-1:0] wrAddr,
  input  logic [WIDTH-1:0]         wrData
);
  logic [WIDTH-1:0] regs [1:COUNT-1];

  genvar g;
  generate
    for (g = 1; g < COUNT; g++) begin : gReg
      always_ff @(posedge clk) begin
        if (!rstN) regs[g] <= '0;
        else if (wrEn && wrAddr == g) regs[g] <= wrData;
      end
    end
  endgenerate

  always_comb begin
    rdDataA = (rdAddrA == '0) ? '0 : regs[rdAddrA];
    rdDataB = (rdAddrB == '0) ? '0 : regs[rdAddrB];
  end
endmodule

// File: rtl/mcDatapath.sv
module mcDatapath
  import mcPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         ctl,
  input  logic [XLEN-1:0]  memRdata,
  output logic [XLEN-1:0]  memAddr,
  output logic [XLEN-1:0]  memWdata,
  output logic             memWe,
  output logic [5:0]       opcode,
  output logic [5:0]       funct,
  output logic             aluZero,
  output logic [XLEN-1:0]  pcVal
);
  localparam int EXT_W = XLEN - IMM_W;

  logic [XLEN-1:0] pc, ir, mdr, regA, regB, aluOut, target;
  logic [XLEN-1:0] rfA, rfB, immExt, aluInA, aluInB, aluRes, wbData, pcNext;
  logic [REG_IDX_W-1:0] wbAddr;
  logic pcEn;

  assign opcode = ir[31:26];
  assign funct  = ir[5:0];
  assign immExt = {{EXT_W{ir[IMM_W-1]}}, ir[IMM_W-1:0]};
  assign pcVal  = pc;

  mcRegFile #(.WIDTH(XLEN), .COUNT(REG_COUNT)) uRegs (
    .clk(clk), .rstN(rstN),
    .rdAddrA(ir[25:21]), .rdAddrB(ir[20:16]),
    .rdDataA(rfA), .rdDataB(rfB),
    .wrEn(ctl.regWrite), .wrAddr(wbAddr), .wrData(wbData)
  );

  always_comb begin
    aluInA = ctl.srcAReg ? regA : pc;
    case (ctl.srcB)
      SRCB_REG:   aluInB = regB;
      SRCB_FOUR:  aluInB = 32'd4;
      SRCB_IMM:   aluInB = immExt;
      default:    aluInB = {immExt[XLEN-3:0], 2'b00};
    endcase
  end

  mcAlu #(.WIDTH(XLEN)) uAlu (
    .opA(aluInA), .opB(aluInB), .sub(ctl.aluSub),
    .result(aluRes), .zero(aluZero)
  );

  always_comb begin
    wbAddr   = ctl.regDstRd ? ir[15:11] : ir[20:16];
    wbData   = ctl.memToReg ? mdr : aluOut;
    pcNext   = ctl.pcSrcTarget ? target : aluRes;
    pcEn     = ctl.pcWrite | (ctl.pcWriteCond & aluZero);
    memAddr  = ctl.iOrD ? aluOut : pc;
    memWdata = regB;
    memWe    = ctl.memWrite;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc     <= '0;
      ir     <= '0;
      mdr    <= '0;
      regA   <= '0;
      regB   <= '0;
      aluOut <= '0;
      target <= '0;
    end else begin
      regA <= rfA;
      regB <= rfB;
      if (pcEn)            pc     <= pcNext;
      if (ctl.irWrite)     ir     <= memRdata;
      if (ctl.mdrWrite)    mdr    <= memRdata;
      if (ctl.aluOutWrite) aluOut <= aluRes;
      if (ctl.targetWrite) target <= aluRes;
    end
  end
endmodule

// File: rtl/mcControl.sv
module mcControl
  import mcPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output strobes_t   ctl,
  output coreState_e curState
);
  coreState_e state, nextState;

  assign curState = state;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_FETCH;
    else       state <= nextState;
  end

  always_comb begin
    nextState = ST_FETCH;
    case (state)
      ST_FETCH:  nextState = ST_DECODE;
      ST_DECODE: begin
        case (opcode)
          OP_LW, OP_SW: nextState = ST_ADDR;
          OP_ADDI:      nextState = ST_EXEI;
          OP_BEQ:       nextState = ST_BRANCH;
          OP_RTYPE:     nextState = (funct == FN_ADD) ? ST_EXER : ST_FETCH;
          default:      nextState = ST_FETCH;
        endcase
      end
      ST_ADDR:   nextState = (opcode == OP_LW) ? ST_MEMRD : ST_MEMWR;
      ST_MEMRD:  nextState = ST_WBMEM;
      ST_EXEI:   nextState = ST_WBI;
      ST_EXER:   nextState = ST_WBR;
      default:   nextState = ST_FETCH;
    endcase
  end

  always_comb begin
    ctl = '0;
    ctl.srcB = SRCB_REG;
    case (state)
      ST_FETCH: begin
        ctl.irWrite = 1'b1;
        ctl.pcWrite = 1'b1;
        ctl.srcB    = SRCB_FOUR;
      end
      ST_DECODE: begin
        ctl.srcB        = SRCB_IMMSH;
        ctl.targetWrite = (opcode == OP_BEQ);
      end
      ST_ADDR, ST_EXEI: begin
        ctl.srcAReg     = 1'b1;
        ctl.srcB        = SRCB_IMM;
        ctl.aluOutWrite = 1'b1;
      end
      ST_MEMRD: begin
        ctl.iOrD     = 1'b1;
        ctl.mdrWrite = 1'b1;
      end
      ST_WBMEM: begin
        ctl.regWrite = 1'b1;
        ctl.memToReg = 1'b1;
      end
      ST_MEMWR: begin
        ctl.iOrD     = 1'b1;
        ctl.memWrite = 1'b1;
      end
      ST_WBI: ctl.regWrite = 1'b1;
      ST_EXER: begin
        ctl.srcAReg     = 1'b1;
        ctl.srcB        = SRCB_REG;
        ctl.aluOutWrite = 1'b1;
      end
      ST_WBR: begin
        ctl.regWrite = 1'b1;
        ctl.regDstRd = 1'b1;
      end
      ST_BRANCH: begin
        ctl.srcAReg     = 1'b1;
        ctl.srcB        = SRCB_REG;
        ctl.aluSub      = 1'b1;
        ctl.pcWriteCond = 1'b1;
        ctl.pcSrcTarget = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mcCore.sv
module mcCore
  import mcPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  output logic [31:0] memAddr,
  output logic [31:0] memWdata,
  output logic        memWe,
  input  logic [31:0] memRdata
);
  strobes_t   ctl;
  coreState_e curState;
  logic [5:0] opcode, funct;
  logic       aluZero;
  logic [XLEN-1:0] pcVal;

  mcControl uCtl (
    .clk(clk), .rstN(rstN), .opcode(opcode), .funct(funct),
    .ctl(ctl), .curState(curState)
  );

  mcDatapath uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe),
    .opcode(opcode), .funct(funct), .aluZero(aluZero), .pcVal(pcVal)
  );
endmodule

// File: rtl/mcCoreChecker.sv
module mcCoreChecker (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] memAddr,
  input logic        memWe,
  input logic        irWrite,
  input logic        iOrD,
  input logic        targetWrite,
  input logic        pcWriteCond,
  input logic [31:0] pcVal
);
  assert_fetch_addr_R2: assert property (@(posedge clk) disable iff (!rstN)
    irWrite |-> memAddr == pcVal);

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    irWrite |=> pcVal == $past(pcVal) + 32'd4);

  assert_store_addr_src_R7: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> iOrD);

  assert_store_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> !memWe);

  assert_compare_follows_R8: assert property (@(posedge clk) disable iff (!rstN)
    targetWrite |=> pcWriteCond);

  assert_no_write_in_fetch_R2: assert property (@(posedge clk) disable iff (!rstN)
    irWrite |-> !memWe);
endmodule

bind mcCore mcCoreChecker uChk (
  .clk(clk), .rstN(rstN), .memAddr(memAddr), .memWe(memWe),
  .irWrite(ctl.irWrite), .iOrD(ctl.iOrD), .targetWrite(ctl.targetWrite),
  .pcWriteCond(ctl.pcWriteCond), .pcVal(pcVal)
);

// File: tb/tb_mcCore.sv
`timescale 1ns/1ps
module tb_mcCore;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] memAddr, memWdata, memRdata;
  logic memWe;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] addr;
    logic [31:0] data;
    int          at;
    string       req;
  } expStore_t;

  expStore_t expQ[$];
  logic [31:0] mem [0:63];

  always #2 clk = ~clk;

  mcCore dut (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memWdata(memWdata),
    .memWe(memWe), .memRdata(memRdata)
  );

  assign memRdata = mem[memAddr[7:2]];

  always @(posedge clk) begin
    if (memWe) mem[memAddr[7:2]] <= memWdata;
    if (rstN) cyc <= cyc + 1;
  end

  function automatic logic [31:0] encI(input logic [5:0] op, input logic [4:0] rs,
                                       input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] encR(input logic [4:0] rs, input logic [4:0] rt,
                                       input logic [4:0] rd, input logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic pushExp(input logic [31:0] a, input logic [31:0] d, input int t,
                         input string r);
    expStore_t e;
    e.addr = a; e.data = d; e.at = t; e.req = r;
    expQ.push_back(e);
  endtask

  // Monitor: every store observed at the port is matched against the queue
  always @(negedge clk) begin
    if (rstN && memWe) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R8", "unexpected store addr", memAddr, 32'hFFFF_FFFF);
      end else begin
        expStore_t e;
        e = expQ.pop_front();
        check(memAddr == e.addr, e.req, "store address", memAddr, e.addr);
        check(memWdata == e.data, e.req, "store data", memWdata, e.data);
        check(cyc == e.at, e.req, "store cycle", cyc, e.at);
      end
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    mem[0]  = encI(6'h08, 5'd0, 5'd1, 16'd5);        // r1 = 5
    mem[1]  = encI(6'h08, 5'd1, 5'd2, 16'hFFFD);     // r2 = 2
    mem[2]  = encR(5'd1, 5'd2, 5'd3, 6'h20);         // r3 = 7
    mem[3]  = encI(6'h2B, 5'd0, 5'd3, 16'h0080);
    mem[4]  = encI(6'h23, 5'd0, 5'd4, 16'h0084);
    mem[5]  = encI(6'h2B, 5'd0, 5'd4, 16'h0088);
    mem[6]  = encI(6'h08, 5'd0, 5'd0, 16'd9);        // write to r0
    mem[7]  = encI(6'h2B, 5'd0, 5'd0, 16'h008C);
    mem[8]  = encI(6'h04, 5'd1, 5'd2, 16'd2);        // not taken
    mem[9]  = encI(6'h2B, 5'd0, 5'd2, 16'h0090);
    mem[10] = encI(6'h04, 5'd3, 5'd3, 16'd1);        // taken, skips 11
    mem[11] = encI(6'h2B, 5'd0, 5'd1, 16'h0094);
    mem[12] = 32'hFC00_0000;                         // unsupported
    mem[13] = encI(6'h08, 5'd0, 5'd5, 16'h0040);
    mem[14] = encI(6'h2B, 5'd5, 5'd1, 16'h0060);
    mem[15] = encI(6'h04, 5'd0, 5'd0, 16'hFFFF);     // loop on itself
    mem[33] = 32'h1234_5678;

    // Driver: expected stores with their cycle numbers (cycle 0 = first fetch)
    pushExp(32'h80, 32'd7, 15, "R5");           // addi, addi, add: R4 R5 R7
    pushExp(32'h88, 32'h1234_5678, 24, "R6");   // load of 5 cycles
    pushExp(32'h8C, 32'd0, 32, "R9");           // r0 stays zero
    pushExp(32'h90, 32'd2, 39, "R8");           // not-taken branch, 3 cycles
    pushExp(32'hA0, 32'd5, 52, "R10");          // taken branch + unsupported op

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(memAddr == 32'h0, "R1", "address in reset", memAddr, 32'h0);
    check(memWe == 1'b0, "R1", "write strobe in reset", {31'd0, memWe}, 32'h0);
    rstN = 1'b1;
    #0.5;
    check(memAddr == 32'h0, "R1", "first fetch address", memAddr, 32'h0);
    check(memRdata == mem[0], "R3", "first instruction word", memRdata, mem[0]);
    wait (cyc >= 100);
    @(negedge clk);
    check(expQ.size() == 0, "R7", "stores still pending", expQ.size(), 32'd0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", 32'd0, 32'd1);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule